// File: doc/BRIEF.md
# Banked Private Peripheral Address Decoder

This block decodes accesses to a 4 KB private peripheral region that up to four processor cores share. Each access carries a 12-bit offset and the 2-bit ID of the core that issued it. The block sorts every access into one of three groups: a small set of coherence-control registers, the per-core interrupt-controller CPU-interface windows, or a timer and watchdog pair per core. It answers the coherence-control group itself. It forwards the other two groups as one-hot instance select lines, a local offset, and the write strobe and data. The read data of the selected instance is returned on the response bus.

Two kinds of window reach the same banked instances. An alias window always resolves to the core that issued the access. Explicit windows name one core's bank by address. A bank at or above the configured core count does not exist: reads of it return zero and writes to it are dropped. The interrupt and timer instances themselves live outside this block.

Top module: `core_local_decoder`

## Requirements
- R1: Offsets 0x000-0x0FF belong to the coherence-control group, 0x100-0x5FF to the interrupt interfaces and 0x600-0xAFF to the timers. An access at 0xB00 or above asserts no select line, reads zero and raises no error.
- R2: An interrupt-interface access at offset 0x100-0x1FF selects the bank of the requesting core (`req_cpu`). The forwarded offset is the access offset's bits 7:0.
- R3: An interrupt-interface access at offset 0x200-0x5FF selects bank (offset - 0x200) >> 8. The forwarded offset is bits 7:0.
- R4: A timer access at offset 0x600-0x6FF targets the requesting core. From 0x700 upward it targets core (offset - 0x700) >> 8.
- R5: The timer instance selected is target core × 2 + offset bit 5, so bit 5 set picks the watchdog. The forwarded offset is bits 3:0, zero-extended to 8 bits.
- R6: When the target core is at or above NCPU, no select line rises, `fwd_write` stays low and the read data is zero. This holds for both alias and explicit windows.
- R7: A write to offset 0x00 stores bit 0 of the write data in the coherence enable bit. The bit resets to 0, and a read of 0x00 returns it in bit 0 with the other bits zero.
- R8: A read of offset 0x04 returns ((2^NCPU) - 1) << 4 ORed with NCPU - 1.
- R9: Reads of offsets 0x08 and 0x0C return zero. A write to 0x0C, or to any other register offset, leaves the enable bit unchanged.
- R10: An access to any coherence-control offset other than 0x00, 0x04, 0x08 or 0x0C reads zero and sets `rsp_err` for exactly the following cycle.
- R11: `fwd_write` is high only while a valid write asserts a select line, and `fwd_wdata` carries `req_wdata`. A read returns the `DW`-bit slice of the selected instance's read-data bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_off | input | 12 | Offset inside the private region |
| req_cpu | input | 2 | ID of the issuing core |
| req_wdata | input | DW | Write data |
| rsp_rdata | output | DW | Read data for the current access |
| rsp_err | output | 1 | One-cycle flag after an access to an unknown register offset |
| gic_sel | output | NCPU | One-hot select of an interrupt-interface bank |
| tmr_sel | output | 2*NCPU | One-hot select of a timer (even) or watchdog (odd) instance |
| fwd_offset | output | 8 | Local offset forwarded to the selected instance |
| fwd_write | output | 1 | Write strobe to the selected instance |
| fwd_wdata | output | DW | Write data to the selected instance |
| gic_rdata | input | NCPU*DW | Read data of the interrupt banks, bank i in slice i |
| tmr_rdata | input | 2*NCPU*DW | Read data of the timer instances, instance j in slice j |

## Verification
The bench is built with three cores. It sweeps every word offset of the region with each of the four requester IDs. Each instance returns a distinct tag on its read-data slice, so a wrong bank, a timer/watchdog swap or a leak from a missing bank shows up in `rsp_rdata` as well as in the select lines. Requester ID 3 on the alias windows and the explicit windows of bank 3 hit the missing-core case, and offsets from 0xB00 up hit the empty range. Directed accesses cover the register group: enable-bit writes with upper data bits set, writes to 0x0C and to unknown offsets that must leave the bit alone, the configuration word, and the timing of the error pulse.

// File: rtl/ppd_pkg.sv
package ppd_pkg;

  localparam int OFF_W  = 12;
  localparam int LOFF_W = 8;

  typedef enum logic [1:0] {
    RG_SNOOP = 2'd0,
    RG_INTC  = 2'd1,
    RG_TIMER = 2'd2,
    RG_NONE  = 2'd3
  } region_e;

  // Group that an offset falls in.
  function automatic region_e region_of(logic [OFF_W-1:0] off);
    if (off < 12'h100)      return RG_SNOOP;
    else if (off < 12'h600) return RG_INTC;
    else if (off < 12'hB00) return RG_TIMER;
    else                    return RG_NONE;
  endfunction

  // Bank number of an explicit per-core window starting at base.
  function automatic logic [1:0] bank_of(logic [OFF_W-1:0] off, logic [OFF_W-1:0] base);
    logic [OFF_W-1:0] d;
    d = off - base;
    return d[9:8];
  endfunction

  // Configuration word: core mask from bit 4, count minus one in low bits.
  function automatic logic [31:0] cfg_word(int n);
    logic [31:0] mask;
    mask = (32'd1 << n) - 32'd1;
    return (mask << 4) | 32'(n - 1);
  endfunction

  function automatic logic known_reg(logic [LOFF_W-1:0] o);
    return (o == 8'h00) || (o == 8'h04) || (o == 8'h08) || (o == 8'h0C);
  endfunction

endpackage

// File: rtl/ppd_region_decode.sv
module ppd_region_decode
  import ppd_pkg::*;
#(
  parameter int NCPU = 4
) (
  input  logic [OFF_W-1:0]  off,
  input  logic [1:0]        cpu,
  output region_e           region,
  output logic [1:0]        tgt,
  output logic              tgt_ok,
  output logic [2:0]        tmr_idx,
  output logic [LOFF_W-1:0] loc_off
);

  always_comb begin
    region  = region_of(off);
    tgt     = cpu;
    loc_off = '0;
    case (region)
      RG_INTC: begin
        if (off >= 12'h200) tgt = bank_of(off, 12'h200);
        loc_off = off[7:0];
      end
      RG_TIMER: begin
        if (off >= 12'h700) tgt = bank_of(off, 12'h700);
        loc_off = {4'b0000, off[3:0]};
      end
      default: ;
    endcase
    tgt_ok  = int'(tgt) < NCPU;
    tmr_idx = {tgt, off[5]};
  end

endmodule

// File: rtl/ppd_snoop_regs.sv
module ppd_snoop_regs
  import ppd_pkg::*;
#(
  parameter int NCPU = 4,
  parameter int DW   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic              wr,
  input  logic [LOFF_W-1:0] off,
  input  logic              wbit,
  output logic [DW-1:0]     rdata,
  output logic              bad_off,
  output logic              en_q,
  output logic              err_q
);

  localparam logic [31:0] CFG = cfg_word(NCPU);

  assign bad_off = acc && !known_reg(off);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      err_q <= bad_off;
      if (acc && wr && off == 8'h00) en_q <= wbit;
    end
  end

  always_comb begin
    rdata = '0;
    if (acc) begin
      case (off)
        8'h00:   rdata = DW'({31'b0, en_q});
        8'h04:   rdata = DW'(CFG);
        default: rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/ppd_route.sv
module ppd_route
  import ppd_pkg::*;
#(
  parameter int NCPU = 4,
  parameter int DW   = 32
) (
  input  logic                   valid,
  input  region_e                region,
  input  logic [1:0]             tgt,
  input  logic                   tgt_ok,
  input  logic [2:0]             tmr_idx,
  input  logic [DW-1:0]          snoop_rdata,
  input  logic [NCPU*DW-1:0]     gic_rdata,
  input  logic [2*NCPU*DW-1:0]   tmr_rdata,
  output logic [NCPU-1:0]        gic_sel,
  output logic [2*NCPU-1:0]      tmr_sel,
  output logic [DW-1:0]          rdata
);

  localparam int NTMR = 2 * NCPU;

  logic gic_hit, tmr_hit;
  assign gic_hit = valid && tgt_ok && region == RG_INTC;
  assign tmr_hit = valid && tgt_ok && region == RG_TIMER;

  for (genvar i = 0; i < NCPU; i++) begin : g_gic
    assign gic_sel[i] = gic_hit && (int'(tgt) == i);
  end
  for (genvar j = 0; j < NTMR; j++) begin : g_tmr
    assign tmr_sel[j] = tmr_hit && (int'(tmr_idx) == j);
  end

  always_comb begin
    rdata = snoop_rdata;
    for (int i = 0; i < NCPU; i++)
      if (gic_sel[i]) rdata = gic_rdata[i*DW +: DW];
    for (int j = 0; j < NTMR; j++)
      if (tmr_sel[j]) rdata = tmr_rdata[j*DW +: DW];
  end

endmodule

// File: rtl/core_local_decoder.sv
module core_local_decoder
  import ppd_pkg::*;
#(
  parameter int NCPU = 4,
  parameter int DW   = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [11:0]            req_off,
  input  logic [1:0]             req_cpu,
  input  logic [DW-1:0]          req_wdata,
  output logic [DW-1:0]          rsp_rdata,
  output logic                   rsp_err,
  output logic [NCPU-1:0]        gic_sel,
  output logic [2*NCPU-1:0]      tmr_sel,
  output logic [7:0]             fwd_offset,
  output logic                   fwd_write,
  output logic [DW-1:0]          fwd_wdata,
  input  logic [NCPU*DW-1:0]     gic_rdata,
  input  logic [2*NCPU*DW-1:0]   tmr_rdata
);

  region_e           region;
  logic [1:0]        tgt;
  logic              tgt_ok;
  logic [2:0]        tmr_idx;
  logic [LOFF_W-1:0] loc_off;
  logic [DW-1:0]     snoop_rdata;
  logic              snoop_acc;
  logic              bad_off;
  logic              coh_en;
  logic              err_q;

  ppd_region_decode #(.NCPU(NCPU)) u_dec (
    .off     (req_off),
    .cpu     (req_cpu),
    .region  (region),
    .tgt     (tgt),
    .tgt_ok  (tgt_ok),
    .tmr_idx (tmr_idx),
    .loc_off (loc_off)
  );

  assign snoop_acc = req_valid && region == RG_SNOOP;

  ppd_snoop_regs #(.NCPU(NCPU), .DW(DW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc     (snoop_acc),
    .wr      (req_write),
    .off     (req_off[7:0]),
    .wbit    (req_wdata[0]),
    .rdata   (snoop_rdata),
    .bad_off (bad_off),
    .en_q    (coh_en),
    .err_q   (err_q)
  );

  ppd_route #(.NCPU(NCPU), .DW(DW)) u_route (
    .valid       (req_valid),
    .region      (region),
    .tgt         (tgt),
    .tgt_ok      (tgt_ok),
    .tmr_idx     (tmr_idx),
    .snoop_rdata (snoop_rdata),
    .gic_rdata   (gic_rdata),
    .tmr_rdata   (tmr_rdata),
    .gic_sel     (gic_sel),
    .tmr_sel     (tmr_sel),
    .rdata       (rsp_rdata)
  );

  assign rsp_err    = err_q;
  assign fwd_offset = loc_off;
  assign fwd_write  = req_valid && req_write && ((|gic_sel) || (|tmr_sel));
  assign fwd_wdata  = req_wdata;

endmodule

// File: rtl/ppd_checker.sv
module ppd_checker #(
  parameter int NCPU = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [11:0]       req_off,
  input logic              wbit,
  input logic [NCPU-1:0]   gic_sel,
  input logic [2*NCPU-1:0] tmr_sel,
  input logic              fwd_write,
  input logic              rsp_err,
  input logic              coh_en
);

  logic [11:0] rel;
  logic        en_wr;
  assign rel   = req_off - 12'h200;
  assign en_wr = req_valid && req_write && req_off == 12'h000;

  p_gic_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gic_sel));
  p_tmr_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tmr_sel));
  p_group_exclusive_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !((|gic_sel) && (|tmr_sel)));
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (gic_sel == '0 && tmr_sel == '0 && !fwd_write));
  p_missing_bank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_off >= 12'h200 && req_off < 12'h600 && int'(rel[9:8]) >= NCPU)
    |-> gic_sel == '0);
  p_err_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> $past(req_valid && req_off < 12'h100));
  p_en_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> coh_en == $past(wbit));
  p_en_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr |=> $stable(coh_en));

endmodule

bind core_local_decoder ppd_checker #(.NCPU(NCPU)) u_ppd_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_off   (req_off),
  .wbit      (req_wdata[0]),
  .gic_sel   (gic_sel),
  .tmr_sel   (tmr_sel),
  .fwd_write (fwd_write),
  .rsp_err   (rsp_err),
  .coh_en    (coh_en)
);

// File: tb/test_core_local_decoder.sv
module test_core_local_decoder;

  localparam int N  = 3;
  localparam int DW = 32;

  logic              clk = 0;
  logic              rst_n = 0;
  logic              req_valid = 0;
  logic              req_write = 0;
  logic [11:0]       req_off = '0;
  logic [1:0]        req_cpu = '0;
  logic [DW-1:0]     req_wdata = '0;
  logic [DW-1:0]     rsp_rdata;
  logic              rsp_err;
  logic [N-1:0]      gic_sel;
  logic [2*N-1:0]    tmr_sel;
  logic [7:0]        fwd_offset;
  logic              fwd_write;
  logic [DW-1:0]     fwd_wdata;
  logic [N*DW-1:0]   gic_rdata;
  logic [2*N*DW-1:0] tmr_rdata;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  for (genvar i = 0; i < N; i++) begin : g_gd
    assign gic_rdata[i*DW +: DW] = 32'hA000_0000 + i;
  end
  for (genvar j = 0; j < 2*N; j++) begin : g_td
    assign tmr_rdata[j*DW +: DW] = 32'hB000_0000 + j;
  end

  core_local_decoder #(.NCPU(N), .DW(DW)) i_core_local_decoder (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_off(req_off), .req_cpu(req_cpu), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .gic_sel(gic_sel),
    .tmr_sel(tmr_sel), .fwd_offset(fwd_offset), .fwd_write(fwd_write),
    .fwd_wdata(fwd_wdata), .gic_rdata(gic_rdata), .tmr_rdata(tmr_rdata)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(logic wr, int off, logic [31:0] data);
    @(negedge clk);
    req_valid = 1;
    req_write = wr;
    req_off   = 12'(off);
    req_wdata = data;
    #5;
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 0;
    req_write = 0;
    #5;
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #5;
    // R7: reset value of the enable bit, no error
    chk("R7 reset", {rsp_err, 31'b0}, 64'h0);
    access(0, 'h000, 0);
    chk("R7 reset read", rsp_rdata, 64'h0);

    // Exhaustive word sweep with every requester ID (R1..R6, R11)
    for (int off = 'h100; off < 'h1000; off += 4) begin
      for (int cpu = 0; cpu < 4; cpu++) begin
        int t, idx, lo, rd;
        logic [N-1:0] eg;
        logic [2*N-1:0] et;
        string tag;
        eg = '0; et = '0; lo = 0; rd = 0;
        if (off < 'h600) begin
          t   = (off < 'h200) ? cpu : (off >> 8) - 2;
          tag = (off < 'h200) ? "R2" : "R3";
          lo  = off & 'hFF;
          if (t < N) begin eg[t] = 1; rd = 'hA000_0000 + t; end
          else tag = "R6";
        end else if (off < 'hB00) begin
          t   = (off < 'h700) ? cpu : (off >> 8) - 7;
          idx = t * 2 + ((off >> 5) & 1);
          tag = (off & 'h20) ? "R5" : "R4";
          lo  = off & 'hF;
          if (t < N) begin et[idx] = 1; rd = 'hB000_0000 + idx; end
          else tag = "R6";
        end else begin
          tag = "R1";
        end
        @(negedge clk);
        req_valid = 1; req_write = 0; req_cpu = 2'(cpu); req_off = 12'(off);
        #5;
        chk(tag, {15'b0, gic_sel, tmr_sel, fwd_offset, rsp_rdata},
                 {15'b0, eg, et, 8'(lo), 32'(rd)});
      end
    end

    // R8: configuration word
    req_cpu = 0;
    access(0, 'h004, 0);
    chk("R8 cfg", rsp_rdata, 64'((((1 << N) - 1) << 4) | (N - 1)));

    // R7: only bit 0 kept
    access(1, 'h000, 32'hFFFF_FFFF);
    access(0, 'h000, 0);
    chk("R7 set", rsp_rdata, 64'h1);
    access(1, 'h000, 32'hFFFF_FFFE);
    access(0, 'h000, 0);
    chk("R7 clear", rsp_rdata, 64'h0);

    // R9: status and invalidate read zero, invalidate write has no effect
    access(0, 'h008, 0);
    chk("R9 status", rsp_rdata, 64'h0);
    access(0, 'h00C, 0);
    chk("R9 inval", rsp_rdata, 64'h0);
    access(1, 'h00C, 32'h1);
    access(0, 'h000, 0);
    chk("R9 inval write", rsp_rdata, 64'h0);
    chk("R9 no error", {63'b0, rsp_err}, 64'h0);

    // R10: unknown offset, error one cycle later, read zero
    access(1, 'h010, 32'h1);
    chk("R10 read zero", rsp_rdata, 64'h0);
    @(posedge clk); #2;
    chk("R10 err high", {63'b0, rsp_err}, 64'h1);
    idle();
    @(posedge clk); #2;
    chk("R10 err drop", {63'b0, rsp_err}, 64'h0);
    access(0, 'h000, 0);
    chk("R10 enable untouched", rsp_rdata, 64'h0);
    access(0, 'h0FC, 0);
    @(posedge clk); #2;
    chk("R10 err read", {63'b0, rsp_err}, 64'h1);
    idle();

    // R11: write forwarding to the watchdog of core 0
    access(1, 'h724, 32'hDEAD_BEEF);
    chk("R11 write", {fwd_write, tmr_sel, fwd_offset, fwd_wdata},
                     {1'b1, 6'b000010, 8'h04, 32'hDEAD_BEEF});
    // R6: write to missing bank 3 dropped
    access(1, 'h510, 32'h1234_5678);
    chk("R6 write drop", {fwd_write, gic_sel}, 64'h0);
    req_cpu = 3;
    access(1, 'h640, 32'h1);
    chk("R6 alias drop", {fwd_write, tmr_sel}, 64'h0);
    // R2: alias write from core 2
    req_cpu = 2;
    access(1, 'h1F8, 32'h5);
    chk("R2 alias write", {fwd_write, gic_sel, fwd_offset}, {1'b1, 3'b100, 8'hF8});
    idle();
    chk("R11 idle", {fwd_write, gic_sel, tmr_sel}, 64'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule